// File: doc/BRIEF.md
# Label-Domain Minimum Check Node

This unit is the parity-check processor of a finite-alphabet message-passing decoder. Each of its DC edges carries a W-bit quantizer label in sign-magnitude form: the top bit is the sign, the lower W-1 bits are the magnitude. For every edge the unit returns an extrinsic label. Its sign is the parity of the signs on all other edges. Its magnitude is the smallest magnitude among those other edges.

The labels are processed exactly as they arrive. No normalization factor or offset is applied, and the unit neither takes nor produces two's-complement values. Results leave in the same sign-magnitude label form, ready to be routed to the variable nodes. Internally the unit finds the smallest and second-smallest magnitudes together with the position of the smallest. Each edge then selects one of those two values. A parameter either adds an output register or leaves the path purely combinational.

Top module: `label_min_cnu`

## Requirements
- R1: For edge j, the output sign bit equals the XOR of the input sign bits of every edge except j. A sign bit of 1 means negative.
- R2: For an edge that is not the position of the smallest input magnitude, the output magnitude equals that smallest magnitude.
- R3: At the position of the smallest input magnitude, the output magnitude equals the second-smallest input magnitude.
- R4: When two or more edges share the smallest magnitude, the lowest-indexed one counts as the minimum position, and every edge, that one included, outputs the shared value.
- R5: Magnitudes are passed unscaled and without offset. A zero magnitude on one edge yields zero on all other edges, and a magnitude of 1 is never reduced.
- R6: With the output register enabled (REG_OUT=1), out_vld equals in_vld delayed by exactly one clock, and out_msg holds the result for the vector presented with that in_vld.
- R7: While rst_n is low, out_vld and out_msg are all zeros, even if in_vld is high.
- R8: A cycle with in_vld low leaves out_msg unchanged, whatever in_msg carries.
- R9: When all input magnitudes are at the largest code (all ones), every output magnitude is that largest code, with no saturation adjustment.
- R10: Edge j occupies bits [j*W +: W] of in_msg and out_msg. Its sign is the most significant bit of that field and its magnitude is the remaining W-1 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Marks in_msg as a vector to process |
| in_msg | input | DC*W | Variable-to-check labels, one W-bit field per edge |
| out_vld | output | 1 | Marks out_msg as a fresh result |
| out_msg | output | DC*W | Check-to-variable extrinsic labels, one W-bit field per edge |

## Verification
On every cycle, the assertions check the one-cycle valid delay, the holding of the output while no vector arrives, the extrinsic sign parity on each edge, and an upper bound on each output magnitude: it never exceeds any other edge's input magnitude. Only the bench scenarios can show that the output magnitude is actually equal to the leave-one-out minimum. They also show that the minimum position receives the second minimum, that ties resolve to the lowest index, and that zero and full-scale magnitudes pass through unaltered.

// File: rtl/label_cnu_pkg.sv
package label_cnu_pkg;

    // Smallest check degree the unit supports.
    localparam int unsigned CNU_MIN_DC = 3;

    // Default degree and label width.
    localparam int unsigned CNU_DEF_DC = 6;
    localparam int unsigned CNU_DEF_W  = 4;

    // Sign-bit polarity of a label.
    typedef enum logic {
        SIGN_POS = 1'b0,
        SIGN_NEG = 1'b1
    } sign_e;

endpackage

// File: rtl/cnu_sign_unit.sv
module cnu_sign_unit #(
    parameter int unsigned DC = 6
) (
    input  logic [DC-1:0] sgn_i,
    output logic [DC-1:0] ext_o
);

    logic total;

    // Removing an edge's own sign from the overall parity leaves
    // the parity of all the other edges.
    assign total = ^sgn_i;

    for (genvar j = 0; j < DC; j++) begin : g_ext
        assign ext_o[j] = total ^ sgn_i[j];
    end

endmodule

// File: rtl/cnu_min_pair.sv
module cnu_min_pair #(
    parameter int unsigned DC = 6,
    parameter int unsigned MW = 3,
    parameter int unsigned IW = 3
) (
    input  logic [DC*MW-1:0] mag_i,
    output logic [MW-1:0]    min1_o,
    output logic [MW-1:0]    min2_o,
    output logic [IW-1:0]    idx_o
);

    // Linear scan. Only a strictly smaller value takes the first slot,
    // so ties keep the lowest index and the tied value drops into min2.
    always_comb begin
        min1_o = mag_i[0 +: MW];
        min2_o = '1;
        idx_o  = '0;
        for (int i = 1; i < DC; i++) begin
            if (mag_i[i*MW +: MW] < min1_o) begin
                min2_o = min1_o;
                min1_o = mag_i[i*MW +: MW];
                idx_o  = IW'(i);
            end else if (mag_i[i*MW +: MW] < min2_o) begin
                min2_o = mag_i[i*MW +: MW];
            end
        end
    end

endmodule

// File: rtl/cnu_edge_out.sv
module cnu_edge_out #(
    parameter int unsigned DC      = 6,
    parameter int unsigned W       = 4,
    parameter int unsigned IW      = 3,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [DC-1:0]   ext_sgn_i,
    input  logic [W-2:0]    min1_i,
    input  logic [W-2:0]    min2_i,
    input  logic [IW-1:0]   idx_i,
    output logic            out_vld,
    output logic [DC*W-1:0] out_msg
);

    logic [DC*W-1:0] word;

    // Each edge picks min2 only at the minimum position.
    for (genvar j = 0; j < DC; j++) begin : g_edge
        assign word[j*W +: W] = {ext_sgn_i[j],
                                 (idx_i == IW'(j)) ? min2_i : min1_i};
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_vld <= 1'b0;
                out_msg <= '0;
            end else begin
                out_vld <= in_vld;
                if (in_vld) begin
                    out_msg <= word;
                end
            end
        end
    end else begin : g_comb
        assign out_vld = in_vld;
        assign out_msg = word;
    end

endmodule

// File: rtl/label_min_cnu.sv
module label_min_cnu
    import label_cnu_pkg::*;
#(
    parameter int unsigned DC      = CNU_DEF_DC,
    parameter int unsigned W       = CNU_DEF_W,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [DC*W-1:0] in_msg,
    output logic            out_vld,
    output logic [DC*W-1:0] out_msg
);

    localparam int unsigned MW = W - 1;
    localparam int unsigned IW = (DC > 1) ? $clog2(DC) : 1;

    logic [DC-1:0]    sgn;
    logic [DC*MW-1:0] mag;
    logic [DC-1:0]    ext_sgn;
    logic [MW-1:0]    min1;
    logic [MW-1:0]    min2;
    logic [IW-1:0]    idx;

    // Split every label into its sign bit and magnitude.
    for (genvar g = 0; g < DC; g++) begin : g_split
        assign sgn[g]            = in_msg[g*W + W - 1];
        assign mag[g*MW +: MW]   = in_msg[g*W +: MW];
    end

    cnu_sign_unit #(.DC(DC)) sign_i (
        .sgn_i (sgn),
        .ext_o (ext_sgn)
    );

    cnu_min_pair #(.DC(DC), .MW(MW), .IW(IW)) minp_i (
        .mag_i  (mag),
        .min1_o (min1),
        .min2_o (min2),
        .idx_o  (idx)
    );

    cnu_edge_out #(.DC(DC), .W(W), .IW(IW), .REG_OUT(REG_OUT)) outp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .ext_sgn_i (ext_sgn),
        .min1_i    (min1),
        .min2_i    (min2),
        .idx_i     (idx),
        .out_vld   (out_vld),
        .out_msg   (out_msg)
    );

endmodule

// File: rtl/label_min_cnu_chk.sv
module label_min_cnu_chk #(
    parameter int unsigned DC      = 6,
    parameter int unsigned W       = 4,
    parameter bit          REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_vld,
    input logic [DC*W-1:0] in_msg,
    input logic            out_vld,
    input logic [DC*W-1:0] out_msg
);

    localparam int unsigned MW = W - 1;

    logic [DC-1:0] in_sg;
    for (genvar g = 0; g < DC; g++) begin : g_sg
        assign in_sg[g] = in_msg[g*W + W - 1];
    end

    // R7: the register is cleared while reset is held
    always @(negedge clk) begin
        if (REG_OUT && !rst_n) begin
            p_reset_clear_r7: assert (out_vld == 1'b0 && out_msg == '0);
        end
    end

    if (REG_OUT) begin : g_seq
        p_vld_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |=> out_vld);
        p_vld_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !in_vld |=> !out_vld);
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_vld |=> $stable(out_msg));

        for (genvar j = 0; j < DC; j++) begin : g_j
            p_sign_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
                out_vld |-> (out_msg[j*W + W - 1] == ((^$past(in_sg)) ^ $past(in_sg[j]))));
            for (genvar k = 0; k < DC; k++) begin : g_k
                if (k != j) begin : g_other
                    p_mag_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
                        out_vld |-> (out_msg[j*W +: MW] <= $past(in_msg[k*W +: MW])));
                end
            end
        end
    end else begin : g_comb
        for (genvar j = 0; j < DC; j++) begin : g_j
            p_sign_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
                out_vld |-> (out_msg[j*W + W - 1] == ((^in_sg) ^ in_sg[j])));
            for (genvar k = 0; k < DC; k++) begin : g_k
                if (k != j) begin : g_other
                    p_mag_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
                        out_vld |-> (out_msg[j*W +: MW] <= in_msg[k*W +: MW]));
                end
            end
        end
    end

endmodule

bind label_min_cnu label_min_cnu_chk #(.DC(DC), .W(W), .REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/label_min_cnu_tb_top.sv
module label_min_cnu_tb_top;

    localparam int DC = 6;
    localparam int W  = 4;
    localparam int MW = W - 1;
    localparam logic [MW-1:0] MAXM = '1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_vld = 1'b0;
    logic [DC*W-1:0] in_msg = '0;
    logic            out_vld;
    logic [DC*W-1:0] out_msg;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    bit running = 1'b0;
    logic [DC*W-1:0] last_exp = '0;

    typedef struct {
        logic [DC*W-1:0] msg;
        string           tag;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;   // 50 MHz

    label_min_cnu #(.DC(DC), .W(W), .REG_OUT(1'b1)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_msg  (in_msg),
        .out_vld (out_vld),
        .out_msg (out_msg)
    );

    // Leave-one-out reference taken straight from the requirements.
    function automatic logic [DC*W-1:0] model(input logic [DC*W-1:0] v);
        logic [DC*W-1:0] r;
        r = '0;
        for (int j = 0; j < DC; j++) begin
            logic s;
            logic [MW-1:0] m;
            s = 1'b0;
            m = MAXM;
            for (int k = 0; k < DC; k++) begin
                if (k != j) begin
                    s ^= v[k*W + W - 1];
                    if (v[k*W +: MW] < m) m = v[k*W +: MW];
                end
            end
            r[j*W +: W] = {s, m};
        end
        return r;
    endfunction

    function automatic logic [DC*W-1:0] pack(input logic [DC-1:0] s,
                                             input logic [DC*MW-1:0] m);
        logic [DC*W-1:0] r;
        for (int j = 0; j < DC; j++) r[j*W +: W] = {s[j], m[j*MW +: MW]};
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [DC*W-1:0] act, input logic [DC*W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [DC*W-1:0] v, input string tag);
        exp_t e;
        @(negedge clk);
        in_vld = 1'b1;
        in_msg = v;
        e.msg = model(v);
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input logic [DC*W-1:0] junk);
        @(negedge clk);
        in_vld = 1'b0;
        in_msg = junk;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: sample away from the rising edge.
    always @(posedge clk) begin
        #5;
        if (running) begin
            check(out_vld == in_vld, "R6", {{(DC*W-1){1'b0}}, out_vld},
                  {{(DC*W-1){1'b0}}, in_vld});
            if (out_vld) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R6", out_msg, '0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(out_msg == e.msg, e.tag, out_msg, e.msg);
                    last_exp = e.msg;
                end
            end else begin
                check(out_msg == last_exp, "R8", out_msg, last_exp);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [DC*MW-1:0] m;
        logic [DC-1:0]    s;

        // R7: reset dominates even with in_vld high
        in_vld = 1'b1;
        in_msg = '1;
        repeat (3) begin
            @(posedge clk); #5;
            check(out_vld == 1'b0 && out_msg == '0, "R7", out_msg, '0);
        end
        @(negedge clk);
        in_vld = 1'b0;
        rst_n  = 1'b1;
        @(negedge clk);
        running = 1'b1;

        // R10: one negative edge walked across every field
        for (int p = 0; p < DC; p++) begin
            for (int j = 0; j < DC; j++) m[j*MW +: MW] = MW'(j + 1);
            s = '0;
            s[p] = 1'b1;
            drive(pack(s, m), "R10");
        end

        // R1: random signs over fixed distinct magnitudes
        for (int t = 0; t < 30; t++) begin
            for (int j = 0; j < DC; j++) m[j*MW +: MW] = MW'(DC - j);
            s = DC'($urandom);
            drive(pack(s, m), "R1");
        end

        // R3: unique minimum at every position, second minimum elsewhere
        for (int p = 0; p < DC; p++) begin
            for (int j = 0; j < DC; j++) m[j*MW +: MW] = MW'(6);
            m[p*MW +: MW] = MW'(1);
            m[((p + 3) % DC)*MW +: MW] = MW'(4);
            drive(pack(DC'($urandom), m), "R3");
        end

        // R4: tied minima
        for (int p = 0; p < DC; p++) begin
            for (int j = 0; j < DC; j++) m[j*MW +: MW] = MW'(5);
            m[p*MW +: MW] = MW'(2);
            m[((p + 2) % DC)*MW +: MW] = MW'(2);
            drive(pack(DC'($urandom), m), "R4");
        end
        for (int j = 0; j < DC; j++) m[j*MW +: MW] = MW'(3);
        drive(pack('0, m), "R4");

        // R8: invalid cycles with changing data must not disturb the output
        idle('1);
        idle({(DC*W/2){2'b01}});
        idle('0);

        // R5: zero and unit magnitudes pass through unchanged
        for (int p = 0; p < DC; p++) begin
            for (int j = 0; j < DC; j++) m[j*MW +: MW] = MW'(1);
            m[p*MW +: MW] = '0;
            drive(pack(DC'($urandom), m), "R5");
        end
        for (int j = 0; j < DC; j++) m[j*MW +: MW] = MW'(1);
        drive(pack('1, m), "R5");

        // R9: full-scale magnitudes
        drive(pack(DC'(6'b101100), {DC{MAXM}}), "R9");
        drive(pack('1, {DC{MAXM}}), "R9");

        idle('0);
        idle('1);

        // R2: random vectors, back to back
        for (int t = 0; t < 60; t++) begin
            drive({DC*W/2{2'b00}} ^ DC*W'($urandom), "R2");
        end
        idle('0);
        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R6", DC*W'(sbq.size()), '0);
        finish_run();
    end

endmodule